// File: doc/BRIEF.md
# Dual-Bus GPIO Port with Atomic Bit Updates

This block controls one port of general-purpose pins. It holds one output latch for the port, a direction mask for each of its two register interfaces, a per-pin enable mask for the local interface, and one ownership bit. Software can replace the whole latch, or it can change chosen bits with a single write: OR in a pattern, strip a pattern out, or invert a pattern. No read-modify-write sequence is needed.

Two register interfaces reach the port. The peripheral interface is a short-offset bus behind a bridge. It also carries the ownership bit. The local interface is a low-latency bus with a full 32-bit address. Its register window is decoded at base 0x00C0_0000. It has its own direction and enable masks and its own set, clear and toggle aliases. Both interfaces change the same output latch. When the ownership bit is set, each pin whose local enable bit is 1 takes its direction from the local interface. Every other pin follows the peripheral direction mask. Input pins are read back through a two-flop synchronizer.

Top module: `dual_bus_gpio`

## Requirements
- R1: After reset every register is zero. No pin is driven (`pin_oe` = 0), `pin_out` = 0, and every register reads back as zero on both interfaces.
- R2: A write at offset 0xC changes the latch to latch OR pattern. Bits written as 0 keep their value.
- R3: A write at offset 0x10 changes the latch to latch AND NOT pattern.
- R4: A write at offset 0x14 changes the latch to latch XOR pattern.
- R5: Offsets 0xC, 0x10 and 0x14 are write-only and read as zero. Offset 0x8 on the peripheral interface and offset 0x18 on the local interface read as zero, and writes to them are ignored. A read of offset 0x0 in the cycle after any write that changes the latch returns the new value.
- R6: The local interface responds only when address bits 31..5 match 0x00C0_0000. A write outside that window changes nothing, and a read there returns zero.
- R7: Bit 0 of peripheral offset 0x18 is the ownership bit. It reads back at bit 0. While it is 1, each pin whose local enable bit (local offset 0x8) is 1 takes its output enable from the local direction mask (local offset 0x4, 1 = output). Every other pin takes its output enable from the peripheral direction mask (peripheral offset 0x4).
- R8: A read of offset 0x0 on either interface returns the latch bit for pins whose output is enabled. For input pins it returns `pin_in`, delayed by exactly two clock edges.
- R9: If both interfaces write a latch-changing offset (0x0, 0xC, 0x10 or 0x14) in the same cycle, only the write from the owning interface takes effect. The owner is the local interface when the ownership bit is 1 and the peripheral interface when it is 0. Writes that do not change the latch, made in the same cycle, still take effect.
- R10: A write at offset 0x0 replaces the whole latch with the written value. `pin_out` shows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pb_we | input | 1 | Peripheral interface write strobe |
| pb_addr | input | 5 | Peripheral interface byte offset |
| pb_wdata | input | N | Peripheral interface write data |
| pb_rdata | output | N | Peripheral interface read data, combinational from `pb_addr` |
| lb_we | input | 1 | Local interface write strobe |
| lb_addr | input | 32 | Local interface full byte address |
| lb_wdata | input | N | Local interface write data |
| lb_rdata | output | N | Local interface read data, combinational from `lb_addr` |
| pin_in | input | N | Pin input levels (asynchronous) |
| pin_out | output | N | Output latch value sent to the pads |
| pin_oe | output | N | Per-pin output enable |

## Verification
The bench runs all 256 starting values of the latch through direct, set, clear and toggle writes. A design that mixed up two of the bit operations, or that let zero bits of a pattern through, fails there at once. It sweeps every local enable mask with the ownership bit both off and on. A wrong per-pin mux would show up as a wrong `pin_oe`. It also checks the input path one edge and two edges after a pin changes, to catch a synchronizer that is one flop too short or too long. It fires simultaneous writes from both interfaces under each ownership setting; a reversed priority, or a merge of the two writes, leaves the wrong latch value. Addresses just outside the local window, and the write-only offsets, must leave the latch alone and read as zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Latch-changing operation decoded from a register write.
  typedef enum logic [2:0] {
    DOP_NONE  = 3'd0,
    DOP_WRITE = 3'd1,
    DOP_SET   = 3'd2,
    DOP_CLR   = 3'd3,
    DOP_TOG   = 3'd4
  } dop_e;

  localparam logic [4:0] OFF_DATA = 5'h00;
  localparam logic [4:0] OFF_DIR  = 5'h04;
  localparam logic [4:0] OFF_EN   = 5'h08;
  localparam logic [4:0] OFF_SET  = 5'h0C;
  localparam logic [4:0] OFF_CLR  = 5'h10;
  localparam logic [4:0] OFF_TOG  = 5'h14;
  localparam logic [4:0] OFF_CTRL = 5'h18;

  // Next latch value for one operation.
  function automatic logic [31:0] apply_op(input dop_e op,
                                           input logic [31:0] cur,
                                           input logic [31:0] pat);
    logic [31:0] nxt;
    case (op)
      DOP_WRITE: nxt = pat;
      DOP_SET:   nxt = cur | pat;
      DOP_CLR:   nxt = cur & ~pat;
      DOP_TOG:   nxt = cur ^ pat;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  // Read view of the port: latch on outputs, synchronized pin on inputs.
  function automatic logic [31:0] data_view(input logic [31:0] latch,
                                            input logic [31:0] sync,
                                            input logic [31:0] oe);
    return (latch & oe) | (sync & ~oe);
  endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pkg::*;
#(
  parameter int N        = 8,
  parameter bit HAS_EN   = 1'b0,
  parameter bit HAS_CTRL = 1'b0
) (
  input  logic         we,
  input  logic         hit,
  input  logic [4:0]   off,
  input  logic [N-1:0] view,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] en,
  input  logic         ctrl,
  output dop_e         op,
  output logic         dir_we,
  output logic         en_we,
  output logic         ctrl_we,
  output logic [N-1:0] rdata
);

  logic wr;
  assign wr = we && hit;

  always_comb begin
    op = DOP_NONE;
    if (wr) begin
      case (off)
        OFF_DATA: op = DOP_WRITE;
        OFF_SET:  op = DOP_SET;
        OFF_CLR:  op = DOP_CLR;
        OFF_TOG:  op = DOP_TOG;
        default:  op = DOP_NONE;
      endcase
    end
  end

  assign dir_we = wr && (off == OFF_DIR);

  generate
    if (HAS_EN) begin : g_en
      assign en_we = wr && (off == OFF_EN);
    end else begin : g_no_en
      assign en_we = 1'b0;
    end
    if (HAS_CTRL) begin : g_ctrl
      assign ctrl_we = wr && (off == OFF_CTRL);
    end else begin : g_no_ctrl
      assign ctrl_we = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (off)
        OFF_DATA: rdata = view;
        OFF_DIR:  rdata = dir;
        OFF_EN:   rdata = HAS_EN ? en : '0;
        OFF_CTRL: rdata = HAS_CTRL ? N'(ctrl) : '0;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int N = 8
) (
  input  logic         own_sel,
  input  logic [N-1:0] lb_en,
  input  logic [N-1:0] lb_dir,
  input  logic [N-1:0] pb_dir,
  output logic [N-1:0] own_lb,
  output logic [N-1:0] oe
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign own_lb[i] = own_sel & lb_en[i];
    assign oe[i]     = own_lb[i] ? lb_dir[i] : pb_dir[i];
  end

endmodule

// File: rtl/dual_bus_gpio.sv
module dual_bus_gpio
  import gpio_pkg::*;
#(
  parameter int          N       = 8,
  parameter logic [31:0] LB_BASE = 32'h00C0_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pb_we,
  input  logic [4:0]   pb_addr,
  input  logic [N-1:0] pb_wdata,
  output logic [N-1:0] pb_rdata,
  input  logic         lb_we,
  input  logic [31:0]  lb_addr,
  input  logic [N-1:0] lb_wdata,
  output logic [N-1:0] lb_rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);

  localparam int WIN_LSB = 5;

  logic [N-1:0] port_q, pb_dir_q, lb_dir_q, lb_en_q;
  logic         own_sel;
  logic [N-1:0] sync_in, view, own_lb;

  dop_e pb_op, lb_op, win_op;
  logic pb_dir_we, pb_en_we, pb_ctrl_we;
  logic lb_dir_we, lb_en_we, lb_ctrl_we;
  logic lb_hit;

  // Named events for the checker.
  logic pb_dv, lb_dv, lb_wins, pb_drop, lb_drop;
  logic [N-1:0] win_pat, port_d;

  assign lb_hit = (lb_addr[31:WIN_LSB] == LB_BASE[31:WIN_LSB]);

  gpio_in_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
  );

  gpio_pin_ctl #(.N(N)) u_pins (
    .own_sel(own_sel), .lb_en(lb_en_q), .lb_dir(lb_dir_q),
    .pb_dir(pb_dir_q), .own_lb(own_lb), .oe(pin_oe)
  );

  assign view = N'(data_view(32'(port_q), 32'(sync_in), 32'(pin_oe)));

  gpio_reg_decode #(.N(N), .HAS_EN(1'b0), .HAS_CTRL(1'b1)) u_pb_dec (
    .we(pb_we), .hit(1'b1), .off(pb_addr), .view(view), .dir(pb_dir_q),
    .en('0), .ctrl(own_sel), .op(pb_op), .dir_we(pb_dir_we),
    .en_we(pb_en_we), .ctrl_we(pb_ctrl_we), .rdata(pb_rdata)
  );

  gpio_reg_decode #(.N(N), .HAS_EN(1'b1), .HAS_CTRL(1'b0)) u_lb_dec (
    .we(lb_we), .hit(lb_hit), .off(lb_addr[WIN_LSB-1:0]), .view(view),
    .dir(lb_dir_q), .en(lb_en_q), .ctrl(1'b0), .op(lb_op),
    .dir_we(lb_dir_we), .en_we(lb_en_we), .ctrl_we(lb_ctrl_we),
    .rdata(lb_rdata)
  );

  // Arbitration of latch-changing writes.
  assign pb_dv   = (pb_op != DOP_NONE);
  assign lb_dv   = (lb_op != DOP_NONE);
  assign lb_wins = lb_dv && (!pb_dv || own_sel);
  assign pb_drop = pb_dv && lb_wins;
  assign lb_drop = lb_dv && !lb_wins;
  assign win_op  = lb_wins ? lb_op : pb_op;
  assign win_pat = lb_wins ? lb_wdata : pb_wdata;
  assign port_d  = N'(apply_op(win_op, 32'(port_q), 32'(win_pat)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q   <= '0;
      pb_dir_q <= '0;
      lb_dir_q <= '0;
      lb_en_q  <= '0;
      own_sel  <= 1'b0;
    end else begin
      port_q <= port_d;
      if (pb_dir_we)  pb_dir_q <= pb_wdata;
      if (lb_dir_we)  lb_dir_q <= lb_wdata;
      if (lb_en_we)   lb_en_q  <= lb_wdata;
      if (pb_ctrl_we) own_sel  <= pb_wdata[0];
    end
  end

  assign pin_out = port_q;

  logic unused_ok;
  assign unused_ok = ^{pb_en_we, lb_ctrl_we, own_lb, lb_drop};

endmodule

// File: rtl/gpio_checker.sv
module gpio_checker
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pb_we,
  input logic [4:0]   pb_addr,
  input logic [N-1:0] pb_wdata,
  input logic [N-1:0] pb_rdata,
  input logic         lb_we,
  input logic [N-1:0] lb_wdata,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         own_sel,
  input logic         lb_hit,
  input logic         pb_dv,
  input logic         pb_drop,
  input dop_e         lb_op
);

  logic pb_live;
  assign pb_live = pb_we && !pb_drop;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pb_live && pb_addr == OFF_SET |=>
      (pin_out & $past(pb_wdata)) == $past(pb_wdata));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pb_live && pb_addr == OFF_CLR |=> (pin_out & $past(pb_wdata)) == '0);

  p_tog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pb_live && pb_addr == OFF_TOG |=>
      pin_out == ($past(pin_out) ^ $past(pb_wdata)));

  p_wo_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_addr == OFF_SET || pb_addr == OFF_CLR || pb_addr == OFF_TOG) |->
      pb_rdata == '0);

  p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we && !lb_hit && !pb_dv |=> $stable(pin_out));

  p_pb_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we && pb_addr == OFF_DIR && !own_sel |=> pin_oe == $past(pb_wdata));

  p_owner_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pb_drop && lb_op == DOP_WRITE |=> pin_out == $past(lb_wdata));

  p_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pb_live && pb_addr == OFF_DATA |=> pin_out == $past(pb_wdata));

  logic unused_ok;
  assign unused_ok = ^{lb_we};

endmodule

bind dual_bus_gpio gpio_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_addr(pb_addr),
  .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .lb_we(lb_we),
  .lb_wdata(lb_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .own_sel(own_sel), .lb_hit(lb_hit), .pb_dv(pb_dv),
  .pb_drop(pb_drop), .lb_op(lb_op)
);

// File: tb/tb_dual_bus_gpio.sv
module tb_dual_bus_gpio;

  localparam int N = 8;
  localparam logic [31:0] BASE = 32'h00C0_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pb_we = 1'b0;
  logic [4:0]   pb_addr = '0;
  logic [N-1:0] pb_wdata = '0;
  logic [N-1:0] pb_rdata;
  logic         lb_we = 1'b0;
  logic [31:0]  lb_addr = BASE;
  logic [N-1:0] lb_wdata = '0;
  logic [N-1:0] lb_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_gpio #(.N(N), .LB_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .lb_we(lb_we),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pb_wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk);
    pb_we = 1'b1; pb_addr = a; pb_wdata = d;
    @(negedge clk);
    pb_we = 1'b0;
  endtask

  task automatic lb_wr(input logic [31:0] a, input logic [N-1:0] d);
    @(negedge clk);
    lb_we = 1'b1; lb_addr = a; lb_wdata = d;
    @(negedge clk);
    lb_we = 1'b0;
  endtask

  task automatic both_wr(input logic [4:0] pa, input logic [N-1:0] pd,
                         input logic [31:0] la, input logic [N-1:0] ld);
    @(negedge clk);
    pb_we = 1'b1; pb_addr = pa; pb_wdata = pd;
    lb_we = 1'b1; lb_addr = la; lb_wdata = ld;
    @(negedge clk);
    pb_we = 1'b0; lb_we = 1'b0;
  endtask

  task automatic pb_rd(input logic [4:0] a, output logic [N-1:0] d);
    pb_addr = a; #0.5; d = pb_rdata;
  endtask

  task automatic lb_rd(input logic [31:0] a, output logic [N-1:0] d);
    lb_addr = a; #0.5; d = lb_rdata;
  endtask

  function automatic logic [N-1:0] exp_oe(input bit sel, input logic [N-1:0] en,
                                          input logic [N-1:0] ld,
                                          input logic [N-1:0] pd);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (sel && en[i]) ? ld[i] : pd[i];
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] rd, m, b, c, t, expd;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 oe", 32'(pin_oe), 0);
    chk("R1 out", 32'(pin_out), 0);
    pb_rd(5'h04, rd); chk("R1 pb dir", 32'(rd), 0);
    pb_rd(5'h18, rd); chk("R1 pb ctrl", 32'(rd), 0);
    lb_rd(BASE + 8, rd); chk("R1 lb en", 32'(rd), 0);
    rst_n = 1'b1;

    // All pins outputs on the peripheral side
    pb_wr(5'h04, 8'hFF);
    chk("R7 pb dir oe", 32'(pin_oe), 32'hFF);

    // R10 R2 R3 R4: exhaustive over starting latch value
    for (int a = 0; a < 256; a++) begin
      m = N'(a);
      b = N'(a * 7 + 3);
      c = N'(a * 13 + 5);
      t = N'(a * 29 + 11);
      pb_wr(5'h00, m);
      chk("R10 direct", 32'(pin_out), 32'(m));
      pb_wr(5'h0C, b); m = m | b;
      chk("R2 set", 32'(pin_out), 32'(m));
      pb_rd(5'h00, rd); chk("R5 readback after set", 32'(rd), 32'(m));
      lb_wr(BASE + 32'h10, c); m = m & ~c;
      chk("R3 clear", 32'(pin_out), 32'(m));
      pb_wr(5'h14, t); m = m ^ t;
      chk("R4 toggle", 32'(pin_out), 32'(m));
      lb_rd(BASE, rd); chk("R5 lb readback", 32'(rd), 32'(m));
    end

    // R5: write-only and empty offsets
    pb_rd(5'h0C, rd); chk("R5 pb set reads 0", 32'(rd), 0);
    pb_rd(5'h10, rd); chk("R5 pb clr reads 0", 32'(rd), 0);
    pb_rd(5'h14, rd); chk("R5 pb tog reads 0", 32'(rd), 0);
    lb_rd(BASE + 32'h0C, rd); chk("R5 lb set reads 0", 32'(rd), 0);
    lb_rd(BASE + 32'h14, rd); chk("R5 lb tog reads 0", 32'(rd), 0);
    pb_wr(5'h08, 8'hFF);
    pb_rd(5'h08, rd); chk("R5 pb 0x8 reads 0", 32'(rd), 0);
    chk("R5 pb 0x8 no effect", 32'(pin_oe), 32'hFF);
    lb_wr(BASE + 32'h18, 8'hFF);
    lb_rd(BASE + 32'h18, rd); chk("R5 lb 0x18 reads 0", 32'(rd), 0);
    pb_rd(5'h18, rd); chk("R5 lb 0x18 no ownership", 32'(rd), 0);

    // R6: window decode
    pb_wr(5'h00, 8'h5A);
    lb_wr(BASE + 32'h20, 8'hFF);
    chk("R6 above window", 32'(pin_out), 32'h5A);
    lb_wr(BASE - 32'h4, 8'h00);
    chk("R6 below window", 32'(pin_out), 32'h5A);
    lb_wr(32'h00C1_0000, 8'h33);
    chk("R6 far miss", 32'(pin_out), 32'h5A);
    lb_rd(BASE + 32'h20, rd); chk("R6 miss reads 0", 32'(rd), 0);
    lb_wr(BASE + 32'h0C, 8'h81);
    chk("R6 hit set", 32'(pin_out), 32'hDB);

    // R8: input synchronizer
    pb_wr(5'h00, 8'h3C);
    pb_wr(5'h04, 8'h0F);
    @(negedge clk); pin_in = 8'hA5;
    @(negedge clk);
    pb_rd(5'h00, rd); chk("R8 one edge old", 32'(rd), 32'h0C);
    @(negedge clk);
    pb_rd(5'h00, rd); chk("R8 two edges new", 32'(rd), 32'hAC);
    pin_in = 8'h5A;
    repeat (2) @(negedge clk);
    lb_rd(BASE, rd); chk("R8 lb view", 32'(rd), 32'h5C);

    // R7: ownership sweep
    lb_wr(BASE + 32'h4, 8'hC3);
    pb_wr(5'h04, 8'h2D);
    for (int s = 0; s < 2; s++) begin
      pb_wr(5'h18, N'(s));
      pb_rd(5'h18, rd); chk("R7 ctrl readback", 32'(rd), s);
      for (int e = 0; e < 256; e++) begin
        lb_wr(BASE + 32'h8, N'(e));
        chk("R7 oe", 32'(pin_oe), 32'(exp_oe(s[0], N'(e), 8'hC3, 8'h2D)));
      end
    end
    // R8 with local-owned outputs: pins 7,6,1,0 local-driven (en=FF)
    pb_wr(5'h00, 8'hF0);
    expd = (8'hF0 & 8'hC3) | (pin_in & ~8'hC3);
    pb_rd(5'h00, rd); chk("R8 local-owned view", 32'(rd), 32'(expd));

    // R9: simultaneous writes, local owns
    pb_wr(5'h00, 8'h00);
    both_wr(5'h0C, 8'hFF, BASE, 8'h3C);
    chk("R9 local wins", 32'(pin_out), 32'h3C);
    both_wr(5'h00, 8'h11, BASE + 32'h14, 8'hFF);
    chk("R9 local toggle wins", 32'(pin_out), 32'hC3);
    // peripheral owns
    pb_wr(5'h18, 8'h00);
    both_wr(5'h00, 8'h81, BASE + 32'h14, 8'hFF);
    chk("R9 pb wins", 32'(pin_out), 32'h81);
    both_wr(5'h10, 8'h01, BASE + 32'h0C, 8'h7E);
    chk("R9 pb clear wins", 32'(pin_out), 32'h80);
    // non-conflicting writes in the same cycle both land
    both_wr(5'h04, 8'h66, BASE, 8'h99);
    chk("R9 dir and data both", 32'(pin_out), 32'h99);
    chk("R9 dir lands", 32'(pin_oe), 32'h66);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule